// File: doc/BRIEF.md
# Rectangular Pixel Transfer Sequencer

This block moves a rectangle of 16-bit pixels between a 32-bit host stream and an external pixel array of 1024 columns by 512 rows. A one-cycle start pulse latches a position word and a size word together with a direction and a mask-force option. The block then walks the rectangle in raster order, left to right and row by row. It issues one pixel access per cycle on the array port. Each host word carries two pixels, and the pixel in the low half comes first.

Both host data paths are valid/ready streams. For writes, the block takes a word only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_valid` is low the walk simply waits, and it keeps its position even in the middle of a row. For reads, `rd_valid` stays high and `rd_data` stays unchanged until `rd_ready` is seen high at a clock edge. Control and status pins carry no handshake. The pixel port returns read data one cycle after the cycle in which a read is issued.

Top module: `xfer_rect_top`

## Requirements
- R1: Start column is `pos_word[9:0]` and start row is `pos_word[24:16]`; all other position bits are ignored.
- R2: Width is `((size_word[9:0] - 1) mod 1024) + 1` and height is `((size_word[24:16] - 1) mod 512) + 1`, so a zero field means 1024 columns or 512 rows; other size bits are ignored.
- R3: Pixels are visited in raster order, continuing from one row into the next inside a host word; the low half `[15:0]` of a word is the earlier pixel; when the pixel count is odd, the high half of the last write word is discarded.
- R4: The column address wraps modulo 1024 and the row address wraps modulo 512.
- R5: On a write with `force_mask` high at start, every stored pixel has bit 15 set to 1; a read never stores anything and returns pixels unmodified.
- R6: A write that stalls (`wr_valid` low) between words makes no pixel access, and on resume it continues at the next pixel of the same row.
- R7: With `wr_valid` held high, a write stores one pixel per cycle with no gap, so the first and last store are exactly N-1 cycles apart for N pixels.
- R8: Read words pack two consecutive pixels low-first; on an odd count the high half of the last word is zero; while `rd_ready` is low, `rd_valid` stays high and `rd_data` stays stable.
- R9: `img_ready` rises the cycle after a read start and falls in the cycle after the last read word is taken; it never rises for a write.
- R10: `done` is a one-cycle pulse in the cycle after completion, with `busy` already low; `dirty` pulses with `done` only for writes.
- R11: A start pulse while `busy` is high is ignored.
- R12: After reset, `busy`, `img_ready`, `done`, `dirty`, `wr_ready`, `rd_valid` and `px_en` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_read | input | 1 | Direction at start: 1 read, 0 write |
| force_mask | input | 1 | At start: force bit 15 on stored pixels |
| pos_word | input | 32 | Position word (column, row) |
| size_word | input | 32 | Size word (width, height minus one, wrapping) |
| wr_valid | input | 1 | Host write word valid |
| wr_ready | output | 1 | Block accepts a host write word |
| wr_data | input | 32 | Host write word, two pixels |
| rd_valid | output | 1 | Host read word valid |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | 32 | Host read word, two pixels |
| px_en | output | 1 | Pixel access this cycle |
| px_we | output | 1 | Pixel access is a store |
| px_x | output | 10 | Pixel column |
| px_y | output | 9 | Pixel row |
| px_wdata | output | 16 | Pixel store data |
| px_rdata | input | 16 | Pixel load data, one cycle after the access |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read transfer active |
| done | output | 1 | Completion pulse |
| dirty | output | 1 | Write completion pulse |

## Verification
When a write streams without gaps, the store of a word's high pixel and the acceptance of the next host word happen in the same cycle. The bench triggers this by holding `wr_valid` high through every table transfer. It then confirms that the stores stay back to back, with N-1 cycles from first to last, and that every address and value matches the raster walk. A second overlap happens at the end of a walk. There, the final store must coincide with the withdrawal of `wr_ready`, and `done` must follow one cycle later. The bench checks that the store count is exact and that `done` arrives with `busy` already low.

// File: rtl/xfer_rect_pkg.sv
package xfer_rect_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WWAIT,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI,
    ST_RCAP,
    ST_ROUT
  } xfer_state_e;
endpackage

// File: rtl/xfer_rect_geom.sv
module xfer_rect_geom #(
  parameter int HW = 32,
  parameter int XW = 10,
  parameter int YW = 9,
  localparam int WW = XW + 1,
  localparam int HH = YW + 1
) (
  input  logic [HW-1:0] pos_word,
  input  logic [HW-1:0] size_word,
  output logic [XW-1:0] x0,
  output logic [YW-1:0] y0,
  output logic [WW-1:0] w,
  output logic [HH-1:0] h
);
  logic [XW-1:0] w_m1;
  logic [YW-1:0] h_m1;
  logic unused_bits;

  assign x0   = pos_word[XW-1:0];
  assign y0   = pos_word[16 +: YW];
  assign w_m1 = size_word[XW-1:0] - XW'(1);
  assign h_m1 = size_word[16 +: YW] - YW'(1);
  assign w    = {1'b0, w_m1} + WW'(1);
  assign h    = {1'b0, h_m1} + HH'(1);

  assign unused_bits = ^{pos_word[HW-1:16+YW], pos_word[15:XW],
                         size_word[HW-1:16+YW], size_word[15:XW]};
endmodule

// File: rtl/xfer_rect_walker.sv
module xfer_rect_walker #(
  parameter int XW = 10,
  parameter int YW = 9,
  localparam int WW = XW + 1,
  localparam int HH = YW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [XW-1:0] x0_in,
  input  logic [YW-1:0] y0_in,
  input  logic [WW-1:0] w_in,
  input  logic [HH-1:0] h_in,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic          last
);
  logic [XW-1:0] x0_q;
  logic [YW-1:0] y0_q;
  logic [WW-1:0] w_q;
  logic [HH-1:0] h_q;
  logic [WW-1:0] col;
  logic [HH-1:0] row;
  logic          row_end;

  assign row_end = (col == w_q - WW'(1));
  assign last    = row_end && (row == h_q - HH'(1));
  assign cur_x   = x0_q + col[XW-1:0];
  assign cur_y   = y0_q + row[YW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0_q <= '0;
      y0_q <= '0;
      w_q  <= WW'(1);
      h_q  <= HH'(1);
      col  <= '0;
      row  <= '0;
    end else if (load) begin
      x0_q <= x0_in;
      y0_q <= y0_in;
      w_q  <= w_in;
      h_q  <= h_in;
      col  <= '0;
      row  <= '0;
    end else if (step) begin
      if (row_end) begin
        col <= '0;
        row <= row + HH'(1);
      end else begin
        col <= col + WW'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_rect_ctrl.sv
module xfer_rect_ctrl
  import xfer_rect_pkg::*;
#(
  parameter int PW = 16,
  localparam int HW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_read,
  input  logic          force_mask,
  input  logic          last,
  output logic          load,
  output logic          step,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [HW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [HW-1:0] rd_data,
  output logic          px_en,
  output logic          px_we,
  output logic [PW-1:0] px_wdata,
  input  logic [PW-1:0] px_rdata,
  output logic          busy,
  output logic          img_ready,
  output logic          done,
  output logic          dirty
);
  xfer_state_e   st;
  logic [HW-1:0] wbuf;
  logic [PW-1:0] lo_q, hi_q;
  logic          fin_q, odd_q, mask_q, rd_act, done_q, dirty_q;
  logic [PW-1:0] sel_pix;

  assign busy      = (st != ST_IDLE);
  assign img_ready = rd_act;
  assign done      = done_q;
  assign dirty     = dirty_q;
  assign load      = (st == ST_IDLE) && start;
  assign px_we     = (st == ST_WLO) || (st == ST_WHI);
  assign px_en     = px_we || (st == ST_RLO) || (st == ST_RHI);
  assign step      = px_en;
  assign wr_ready  = (st == ST_WWAIT) || ((st == ST_WHI) && !last);
  assign rd_valid  = (st == ST_ROUT);
  assign rd_data   = {hi_q, lo_q};
  assign sel_pix   = (st == ST_WHI) ? wbuf[HW-1:PW] : wbuf[PW-1:0];
  assign px_wdata  = sel_pix | {mask_q, {(PW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wbuf    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      fin_q   <= 1'b0;
      odd_q   <= 1'b0;
      mask_q  <= 1'b0;
      rd_act  <= 1'b0;
      done_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      dirty_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= start_read ? ST_RLO : ST_WWAIT;
          mask_q <= force_mask && !start_read;
          rd_act <= start_read;
        end
        ST_WWAIT: if (wr_valid) begin
          wbuf <= wr_data;
          st   <= ST_WLO;
        end
        ST_WLO: begin
          if (last) begin
            st      <= ST_IDLE;
            done_q  <= 1'b1;
            dirty_q <= 1'b1;
          end else begin
            st <= ST_WHI;
          end
        end
        ST_WHI: begin
          if (last) begin
            st      <= ST_IDLE;
            done_q  <= 1'b1;
            dirty_q <= 1'b1;
          end else if (wr_valid) begin
            wbuf <= wr_data;
            st   <= ST_WLO;
          end else begin
            st <= ST_WWAIT;
          end
        end
        ST_RLO: begin
          fin_q <= last;
          odd_q <= last;
          st    <= last ? ST_RCAP : ST_RHI;
        end
        ST_RHI: begin
          lo_q  <= px_rdata;
          fin_q <= last;
          st    <= ST_RCAP;
        end
        ST_RCAP: begin
          if (odd_q) begin
            lo_q <= px_rdata;
            hi_q <= '0;
          end else begin
            hi_q <= px_rdata;
          end
          st <= ST_ROUT;
        end
        ST_ROUT: if (rd_ready) begin
          if (fin_q) begin
            st     <= ST_IDLE;
            rd_act <= 1'b0;
            done_q <= 1'b1;
          end else begin
            st <= ST_RLO;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_rect_top.sv
module xfer_rect_top #(
  parameter int PW = 16,
  parameter int XW = 10,
  parameter int YW = 9,
  localparam int HW = 2 * PW,
  localparam int WW = XW + 1,
  localparam int HH = YW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_read,
  input  logic          force_mask,
  input  logic [HW-1:0] pos_word,
  input  logic [HW-1:0] size_word,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [HW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [HW-1:0] rd_data,
  output logic          px_en,
  output logic          px_we,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic [PW-1:0] px_wdata,
  input  logic [PW-1:0] px_rdata,
  output logic          busy,
  output logic          img_ready,
  output logic          done,
  output logic          dirty
);
  logic [XW-1:0] g_x0;
  logic [YW-1:0] g_y0;
  logic [WW-1:0] g_w;
  logic [HH-1:0] g_h;
  logic          w_load, w_step, w_last;

  xfer_rect_geom #(.HW(HW), .XW(XW), .YW(YW)) u_geom (
    .pos_word (pos_word),
    .size_word(size_word),
    .x0       (g_x0),
    .y0       (g_y0),
    .w        (g_w),
    .h        (g_h)
  );

  xfer_rect_walker #(.XW(XW), .YW(YW)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .load (w_load),
    .step (w_step),
    .x0_in(g_x0),
    .y0_in(g_y0),
    .w_in (g_w),
    .h_in (g_h),
    .cur_x(px_x),
    .cur_y(px_y),
    .last (w_last)
  );

  xfer_rect_ctrl #(.PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_read(start_read),
    .force_mask(force_mask),
    .last      (w_last),
    .load      (w_load),
    .step      (w_step),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .px_en     (px_en),
    .px_we     (px_we),
    .px_wdata  (px_wdata),
    .px_rdata  (px_rdata),
    .busy      (busy),
    .img_ready (img_ready),
    .done      (done),
    .dirty     (dirty)
  );
endmodule

// File: rtl/xfer_rect_chk.sv
module xfer_rect_chk #(
  parameter int PW = 16,
  localparam int HW = 2 * PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [HW-1:0] rd_data,
  input logic          px_en,
  input logic          px_we,
  input logic          busy,
  input logic          img_ready,
  input logic          done,
  input logic          dirty
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8

  AST_IMG_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(img_ready) |-> done); // R9

  AST_NO_STORE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> !(px_en && px_we) && !wr_ready); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DIRTY_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> done && !img_ready); // R10

  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    px_en |-> busy); // R6

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R11
endmodule

bind xfer_rect_top xfer_rect_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .px_en    (px_en),
  .px_we    (px_we),
  .busy     (busy),
  .img_ready(img_ready),
  .done     (done),
  .dirty    (dirty)
);

// File: tb/tb_xfer_rect_top.sv
`timescale 1ns/1ps
module tb_xfer_rect_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_read = 1'b0, force_mask = 1'b0;
  logic [31:0] pos_word = '0, size_word = '0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_valid, px_en, px_we, busy, img_ready, done, dirty;
  logic [31:0] rd_data;
  logic [9:0]  px_x;
  logic [8:0]  px_y;
  logic [15:0] px_wdata;
  logic [15:0] px_rdata = '0;

  always #2.5 clk = ~clk;

  xfer_rect_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_read(start_read),
    .force_mask(force_mask), .pos_word(pos_word), .size_word(size_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .px_en(px_en), .px_we(px_we), .px_x(px_x), .px_y(px_y),
    .px_wdata(px_wdata), .px_rdata(px_rdata), .busy(busy),
    .img_ready(img_ready), .done(done), .dirty(dirty)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] mem [int];
  int wx[$], wy[$], wd[$], wc[$];

  function automatic logic [15:0] pat(input int x, input int y);
    return 16'({y[5:0], x[9:0]}) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (px_en) begin
      if (px_we) begin
        mem[{px_y, px_x}] = px_wdata;
        wx.push_back(int'(px_x)); wy.push_back(int'(px_y));
        wd.push_back(int'(px_wdata)); wc.push_back(cyc);
      end else begin
        px_rdata <= mem.exists({px_y, px_x}) ? mem[{px_y, px_x}] : pat(int'(px_x), int'(px_y));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(input logic rd, input logic [31:0] p, input logic [31:0] s,
                      input logic m);
    @(negedge clk);
    start = 1'b1; start_read = rd; pos_word = p; size_word = s; force_mask = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w;
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic stop_send();
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic clear_log();
    wx.delete(); wy.delete(); wd.delete(); wc.delete();
  endtask

  function automatic logic [15:0] pixv(input int t, input int i);
    return 16'((i * 5 + t * 16) & 16'h7FFF);
  endfunction

  typedef struct packed {
    logic [31:0] pos;
    logic [31:0] size;
    logic        mask;
    logic [9:0]  x0;
    logic [8:0]  y0;
    logic [10:0] w;
    logic [9:0]  h;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{32'h0007_0005, 32'h0002_0003, 1'b0, 10'd5,    9'd7,   11'd3,    10'd2},
    '{32'h01FF_03FE, 32'h0002_0004, 1'b1, 10'd1022, 9'd511, 11'd4,    10'd2},
    '{32'h0000_0100, 32'h0001_0000, 1'b0, 10'd256,  9'd0,   11'd1024, 10'd1},
    '{32'h0030_0040, 32'h0003_0001, 1'b1, 10'd64,   9'd48,  11'd1,    10'd3},
    '{32'hFE10_FC08, 32'hF002_FC05, 1'b0, 10'd8,    9'd16,  11'd5,    10'd2},
    '{32'h0000_0200, 32'h0000_0001, 1'b0, 10'd512,  9'd0,   11'd1,    10'd512}
  };

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy && !img_ready && !done && !dirty && !wr_ready && !rd_valid && !px_en,
        "R12", "outputs in reset", {busy, img_ready, done, dirty, wr_ready, rd_valid, px_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_ready && !px_en, "R12", "idle after reset", {busy, wr_ready, px_en}, 0);

    // Table: R1 R2 R3 R4 R5 R7 R10 over several geometries
    foreach (TBL[t]) begin
      int n, bad, fi, ex, ey, ed;
      n = int'(TBL[t].w) * int'(TBL[t].h);
      clear_log();
      kick(1'b0, TBL[t].pos, TBL[t].size, TBL[t].mask);
      for (int k = 0; k < (n + 1) / 2; k++)
        send({pixv(t, 2 * k + 1), pixv(t, 2 * k)});
      stop_send();
      wait_done(seen);
      chk(seen && !busy && dirty, "R10", $sformatf("write %0d done/dirty", t),
          {seen, busy, dirty}, 3'b101);
      chk(wx.size() == n, "R2", $sformatf("write %0d store count", t), wx.size(), n);
      bad = 0; fi = -1;
      for (int i = 0; i < wx.size() && i < n; i++) begin
        ex = (int'(TBL[t].x0) + i % int'(TBL[t].w)) % 1024;
        ey = (int'(TBL[t].y0) + i / int'(TBL[t].w)) % 512;
        ed = int'(pixv(t, i)) | (TBL[t].mask ? 32'h8000 : 0);
        if (wx[i] != ex || wy[i] != ey || wd[i] != ed) begin
          bad++;
          if (fi < 0) fi = i;
        end
      end
      if (fi >= 0) begin
        ex = (int'(TBL[t].x0) + fi % int'(TBL[t].w)) % 1024;
        ey = (int'(TBL[t].y0) + fi / int'(TBL[t].w)) % 512;
        ed = int'(pixv(t, fi)) | (TBL[t].mask ? 32'h8000 : 0);
        chk(0, "R1 R3 R4 R5", $sformatf("write %0d pixel %0d {y,x,d}", t, fi),
            {wy[fi], wx[fi], wd[fi]}, {ey, ex, ed});
      end else begin
        chk(1, "R1 R3 R4 R5", "", 0, 0);
      end
      if (wc.size() == n)
        chk(wc[n - 1] - wc[0] == n - 1, "R7", $sformatf("write %0d store span", t),
            wc[n - 1] - wc[0], n - 1);
      @(negedge clk);
    end

    // R8 R9 R10 R5: read of 3 pixels at (10,20), mask requested but not applied
    begin
      logic [31:0] w0, w1;
      bool_hold: begin end
      clear_log();
      rd_ready = 1'b0;
      kick(1'b1, 32'h0014_000A, 32'h0001_0003, 1'b1);
      chk(img_ready && busy, "R9", "img_ready after read start", {img_ready, busy}, 2'b11);
      while (!rd_valid) @(negedge clk);
      w0 = rd_data;
      begin
        bit held;
        held = 1'b1;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          if (!rd_valid || rd_data != w0) held = 1'b0;
        end
        chk(held, "R8", "read word held under back-pressure", held, 1);
      end
      chk(w0 == {pat(11, 20), pat(10, 20)}, "R8", "read word 0", w0, {pat(11, 20), pat(10, 20)});
      rd_ready = 1'b1;
      @(negedge clk);
      while (!rd_valid) @(negedge clk);
      w1 = rd_data;
      chk(w1 == {16'h0, pat(12, 20)}, "R8", "read word 1 odd tail", w1, {16'h0, pat(12, 20)});
      chk(img_ready, "R9", "img_ready before last take", img_ready, 1);
      @(negedge clk);
      chk(done && !busy && !dirty && !img_ready, "R10", "read done without dirty",
          {done, busy, dirty, img_ready}, 4'b1000);
      @(negedge clk);
      chk(!done, "R10", "done is one cycle", done, 0);
      chk(wx.size() == 0, "R5", "no stores during read", wx.size(), 0);
      rd_ready = 1'b0;
    end

    // R6: stall mid-row, then resume
    begin
      int cnt;
      clear_log();
      kick(1'b0, 32'h0064_0064, 32'h0001_0004, 1'b0);
      send(32'h0002_0001);
      stop_send();
      repeat (2) @(negedge clk);
      cnt = wx.size();
      repeat (5) @(negedge clk);
      chk(wx.size() == cnt && cnt == 2 && !px_en, "R6", "no access while stalled",
          wx.size(), 2);
      send(32'h0004_0003);
      stop_send();
      wait_done(seen);
      chk(seen && wx.size() == 4 && wx[2] == 102 && wx[3] == 103 && wy[3] == 100 &&
          wd[2] == 3 && wd[3] == 4, "R6", "resume at next column",
          (wx.size() > 2) ? wx[2] : -1, 102);
    end

    // R11: start while busy ignored
    begin
      clear_log();
      kick(1'b0, 32'h0032_00C8, 32'h0001_0002, 1'b0);
      kick(1'b1, 32'h003C_012C, 32'h0001_0002, 1'b0);
      chk(!img_ready && wr_ready, "R11", "second start ignored", {img_ready, wr_ready}, 2'b01);
      send(32'h0BBB_0AAA);
      stop_send();
      wait_done(seen);
      chk(seen && dirty && wx.size() == 2 && wx[0] == 200 && wx[1] == 201 && wy[0] == 50,
          "R11", "original transfer kept", (wx.size() > 0) ? wx[0] : -1, 200);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule